// File: doc/BRIEF.md
# Update-Protocol Cache Line Controller

This block is the processor-side controller of a small direct-mapped cache in a snooping multiprocessor. The protocol keeps copies up to date instead of invalidating them. Each resident line holds one data word and is in one of three coherence states: exclusive (the only clean copy), shared (clean, possibly held by other caches) or dirty (the only copy, with memory stale). A separate valid bit marks empty lines; no coherence state means invalid.

The processor presents one request at a time: read, write or clean. It holds the request until the controller pulses ready. The controller resolves hits locally. To reach the rest of the system it drives a single-master bus with a command, an address and a write word, and it waits for a done strobe. A wired-OR shared input tells the controller whether another cache holds the addressed word. The controller samples that input in the done cycle of a bus transaction and uses it to choose the next state. It updates shared copies by writing through to memory. It reaches the exclusive state only when no other cache reports a copy.

Top module: `upd_cache_ctrl`

## Requirements
- R1: After reset, `req_ready_o` and `bus_req_o` are low and every line is empty, so the first access to any index misses.
- R2: A read (`req_op_i`=0) that hits returns the line's word on `resp_rdata_o` with ready, causes no bus transaction, and leaves the line state unchanged.
- R3: A read miss issues a bus read (`bus_cmd_o`=1) to the request address. The line is filled with `bus_rdata_i` as shared if `shared_i` is high in the done cycle, and as exclusive otherwise. The filled word is returned.
- R4: A write (`req_op_i`=1) that hits a dirty line updates only the local word, with no bus transaction.
- R5: A write that hits an exclusive line updates the local word and makes the line dirty, with no bus transaction.
- R6: A write that hits a shared line issues a write-through (`bus_cmd_o`=2) carrying the address and the new word. The line stays shared if `shared_i` is high in that done cycle, and becomes exclusive otherwise.
- R7: A write miss first performs a bus read. If `shared_i` was low at its done cycle, the new word is stored and the line becomes dirty with no further traffic. If it was high, the line is written through as in R6.
- R8: A miss that replaces a dirty line first writes the victim back (`bus_cmd_o`=3) at the victim's own address and word, and only after that write-back completes issues the bus read. A clean victim is dropped without bus traffic.
- R9: A clean request (`req_op_i`=2 or 3) on a resident dirty line writes it back (`bus_cmd_o`=3) and leaves it exclusive. On any other line it completes with no bus traffic.
- R10: Ready is high for exactly one cycle per request. While `bus_req_o` is high and `bus_done_i` is low, the command, address and write word stay stable. Ready is never high together with a bus request.
- R11: `shared_i` matters only in the done cycle; its value in earlier waiting cycles has no effect on the chosen state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present, held until ready |
| req_op_i | input | 2 | 0 read, 1 write, 2/3 clean |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write word |
| req_ready_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | DATA_W | Read result, valid with ready |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_cmd_o | output | 2 | 1 read, 2 write-through, 3 write-back |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_wdata_o | output | DATA_W | Bus write word |
| bus_rdata_i | input | DATA_W | Bus read word, valid with done |
| bus_done_i | input | 1 | Transaction complete strobe |
| shared_i | input | 1 | Wired-OR indication that another cache holds the word |

## Verification
The state choice coincides with the bus completion: the shared input is sampled and the line is rewritten in the same cycle that done arrives. The bench therefore drives `shared_i` to the opposite value during every waiting cycle and sets the intended value only with done, over randomized latencies. It then infers each resulting state from later traffic: a clean triggers a write-back only when the line is dirty, and a write triggers a write-through only when the line is shared. The second coincidence is a victim write-back whose done cycle is immediately followed by the fill read. Zero-latency responses provoke this case, and the bench checks the order and contents of the logged transactions against an independent model.

// File: rtl/upd_cache_pkg.sv
package upd_cache_pkg;
  typedef enum logic [1:0] {
    LS_EXCL   = 2'd0,
    LS_SHARED = 2'd1,
    LS_DIRTY  = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WTHRU = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    C_IDLE, C_LOOK, C_VICT, C_FILL, C_WTHRU, C_CLEAN, C_DONE
  } ctl_st_e;
endpackage

// File: rtl/upd_cache_store.sv
module upd_cache_store
  import upd_cache_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  output line_st_e          rd_st_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  line_st_e          wr_st_i
);
  localparam int LINES = 1 << IDX_W;

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];
  line_st_e          st_q    [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
        st_q[i]    <= LS_EXCL;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
      data_q[wr_idx_i]  <= wr_data_i;
      st_q[wr_idx_i]    <= wr_st_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_st_o    = st_q[rd_idx_i];
endmodule

// File: rtl/upd_cache_lookup.sv
module upd_cache_lookup
  import upd_cache_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  line_st_e         ent_st_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             hit_o,
  output logic             vict_dirty_o
);
  logic tag_eq;
  assign tag_eq       = (ent_tag_i == req_tag_i);
  assign hit_o        = ent_valid_i && tag_eq;
  // resident line for another address that must be written back first
  assign vict_dirty_o = ent_valid_i && !tag_eq && (ent_st_i == LS_DIRTY);
endmodule

// File: rtl/upd_cache_fsm.sv
module upd_cache_fsm
  import upd_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_done_i,
  input  logic              shared_i,
  input  logic              hit_i,
  input  logic              vict_dirty_i,
  input  line_st_e          ent_st_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [DATA_W-1:0] ent_data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output line_st_e          wr_st_o
);
  ctl_st_e           st_q, st_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  bus_cmd_e          cmd;

  logic is_write, is_clean;
  assign is_write = (op_q == 2'd1);
  assign is_clean = op_q[1];
  assign idx_o    = addr_q[IDX_W-1:0];
  assign tag_o    = addr_q[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= C_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (st_q == C_IDLE && req_valid_i) begin
        op_q    <= req_op_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  always_comb begin
    st_d        = st_q;
    rdata_d     = rdata_q;
    wr_en_o     = 1'b0;
    wr_data_o   = ent_data_i;
    wr_st_o     = ent_st_i;
    cmd         = BC_NONE;
    bus_addr_o  = addr_q;
    bus_wdata_o = ent_data_i;
    unique case (st_q)
      C_IDLE: if (req_valid_i) st_d = C_LOOK;
      C_LOOK: begin
        if (is_clean) begin
          st_d = (hit_i && ent_st_i == LS_DIRTY) ? C_CLEAN : C_DONE;
        end else if (hit_i) begin
          if (!is_write) begin
            rdata_d = ent_data_i;
            st_d    = C_DONE;
          end else begin
            wr_en_o   = 1'b1;
            wr_data_o = wdata_q;
            unique case (ent_st_i)
              LS_SHARED: st_d = C_WTHRU;
              LS_EXCL: begin
                wr_st_o = LS_DIRTY;
                st_d    = C_DONE;
              end
              default: st_d = C_DONE;
            endcase
          end
        end else begin
          st_d = vict_dirty_i ? C_VICT : C_FILL;
        end
      end
      C_VICT: begin
        cmd        = BC_WBACK;
        bus_addr_o = {ent_tag_i, idx_o};
        if (bus_done_i) st_d = C_FILL;
      end
      C_FILL: begin
        cmd = BC_READ;
        if (bus_done_i) begin
          wr_en_o = 1'b1;
          if (!is_write) begin
            wr_data_o = bus_rdata_i;
            wr_st_o   = shared_i ? LS_SHARED : LS_EXCL;
            rdata_d   = bus_rdata_i;
            st_d      = C_DONE;
          end else begin
            // fill then write hit: shared copy goes through, else local only
            wr_data_o = wdata_q;
            wr_st_o   = shared_i ? LS_SHARED : LS_DIRTY;
            st_d      = shared_i ? C_WTHRU : C_DONE;
          end
        end
      end
      C_WTHRU: begin
        cmd = BC_WTHRU;
        if (bus_done_i) begin
          wr_en_o = 1'b1;
          wr_st_o = shared_i ? LS_SHARED : LS_EXCL;
          st_d    = C_DONE;
        end
      end
      C_CLEAN: begin
        cmd = BC_WBACK;
        if (bus_done_i) begin
          wr_en_o = 1'b1;
          wr_st_o = LS_EXCL;
          st_d    = C_DONE;
        end
      end
      C_DONE:  st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  assign bus_req_o    = (cmd != BC_NONE);
  assign bus_cmd_o    = cmd;
  assign req_ready_o  = (st_q == C_DONE);
  assign resp_rdata_o = rdata_q;
endmodule

// File: rtl/upd_cache_ctrl.sv
module upd_cache_ctrl
  import upd_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_done_i,
  input  logic              shared_i
);
  logic              ent_valid, hit, vict_dirty, wr_en;
  logic [TAG_W-1:0]  ent_tag, req_tag;
  logic [DATA_W-1:0] ent_data, wr_data;
  logic [IDX_W-1:0]  idx;
  line_st_e          ent_st, wr_st;

  upd_cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(idx), .rd_valid_o(ent_valid), .rd_tag_o(ent_tag),
    .rd_data_o(ent_data), .rd_st_o(ent_st),
    .wr_en_i(wr_en), .wr_idx_i(idx), .wr_tag_i(req_tag),
    .wr_data_i(wr_data), .wr_st_i(wr_st)
  );

  upd_cache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .ent_valid_i(ent_valid), .ent_tag_i(ent_tag), .ent_st_i(ent_st),
    .req_tag_i(req_tag), .hit_o(hit), .vict_dirty_o(vict_dirty)
  );

  upd_cache_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_addr_i, .req_wdata_i,
    .req_ready_o, .resp_rdata_o,
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .bus_rdata_i, .bus_done_i, .shared_i,
    .hit_i(hit), .vict_dirty_i(vict_dirty), .ent_st_i(ent_st),
    .ent_tag_i(ent_tag), .ent_data_i(ent_data),
    .idx_o(idx), .tag_o(req_tag),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_st_o(wr_st)
  );
endmodule

// File: rtl/upd_cache_chk.sv
module upd_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_done_i
);
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o); // R10

  AST_BUS_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_cmd_o)
      && $stable(bus_addr_o) && $stable(bus_wdata_o))); // R10

  AST_NO_READY_WITH_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o); // R10

  AST_READY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> $past(req_valid_i)); // R10

  AST_BUS_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o != 2'd0)); // R3
endmodule

bind upd_cache_ctrl upd_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_done_i(bus_done_i)
);

// File: tb/upd_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module upd_cache_ctrl_tb_top;
  localparam int AW = 6, IW = 2, DW = 16, NL = 4, NA = 64;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, bus_req;
  logic [DW-1:0] resp_rdata, bus_wdata;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_done = 1'b0, shared = 1'b0;

  always #2 clk = ~clk;

  upd_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .resp_rdata_o(resp_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_done_i(bus_done),
    .shared_i(shared)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [NA];
  logic [DW-1:0] ref_mem [NA];
  // model: 0 exclusive, 1 shared, 2 dirty
  bit m_valid [NL];
  int m_tag [NL], m_st [NL];
  logic [DW-1:0] m_data [NL];
  int e_cmd [4], e_addr [4], e_data [4], ecnt;
  int g_cmd [4], g_addr [4], g_data [4], gcnt;
  string etag;
  logic [DW-1:0] exp_rd, got_rd;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] step(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic push(int c, int a, int d);
    e_cmd[ecnt] = c; e_addr[ecnt] = a; e_data[ecnt] = d; ecnt++;
  endtask

  task automatic model(int op, int addr, logic [DW-1:0] wd, bit shf, bit shw);
    int idx = addr % NL, tg = addr / NL;
    bit hit = m_valid[idx] && m_tag[idx] == tg;
    ecnt = 0;
    if (op >= 2) begin
      etag = "R9";
      if (hit && m_st[idx] == 2) begin
        push(3, addr, m_data[idx]); ref_mem[addr] = m_data[idx]; m_st[idx] = 0;
      end
    end else if (hit && op == 0) begin
      etag = "R2"; exp_rd = m_data[idx];
    end else if (hit) begin
      m_data[idx] = wd;
      if (m_st[idx] == 2) etag = "R4";
      else if (m_st[idx] == 0) begin etag = "R5"; m_st[idx] = 2; end
      else begin
        etag = "R6"; push(2, addr, wd); ref_mem[addr] = wd; m_st[idx] = shw ? 1 : 0;
      end
    end else begin
      etag = (op == 0) ? "R3" : "R7";
      if (m_valid[idx] && m_st[idx] == 2) begin
        etag = "R8";
        push(3, m_tag[idx] * NL + idx, m_data[idx]);
        ref_mem[m_tag[idx] * NL + idx] = m_data[idx];
      end
      push(1, addr, 0);
      m_valid[idx] = 1'b1; m_tag[idx] = tg;
      if (op == 0) begin
        m_data[idx] = ref_mem[addr]; exp_rd = ref_mem[addr]; m_st[idx] = shf ? 1 : 0;
      end else begin
        m_data[idx] = wd;
        if (shf) begin push(2, addr, wd); ref_mem[addr] = wd; m_st[idx] = shw ? 1 : 0; end
        else m_st[idx] = 2;
      end
    end
  endtask

  // drive one request, serve the bus, compare against the model
  task automatic do_req(int op, int addr, logic [DW-1:0] wd, bit shf, bit shw, int lat);
    int wc = 0;
    model(op, addr, wd, shf, shw);
    gcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr); req_wdata = wd;
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      if (req_ready) begin
        got_rd = resp_rdata; req_valid = 1'b0;
        break;
      end
      if (bus_req) begin
        if (wc >= lat) begin
          if (gcnt < 4) begin
            g_cmd[gcnt] = int'(bus_cmd); g_addr[gcnt] = int'(bus_addr);
            g_data[gcnt] = int'(bus_wdata);
          end
          gcnt++;
          if (bus_cmd == 2'd1) bus_rdata = mem[bus_addr];
          else mem[bus_addr] = bus_wdata;
          shared = (bus_cmd == 2'd1) ? shf : (bus_cmd == 2'd2) ? shw : 1'b0;
          bus_done = 1'b1; wc = 0;
        end else begin
          // opposite value while waiting: must not be used (R11)
          shared = (bus_cmd == 2'd1) ? !shf : !shw;
          wc++;
        end
      end else shared = 1'b0;
    end
    @(negedge clk);
    chk(!req_ready, "R10", "ready width", int'(req_ready), 0);
    chk(gcnt == ecnt, etag, "bus txn count", gcnt, ecnt);
    if (gcnt == ecnt) for (int i = 0; i < ecnt; i++) begin
      chk(g_cmd[i] == e_cmd[i], etag, "bus cmd", g_cmd[i], e_cmd[i]);
      chk(g_addr[i] == e_addr[i], etag, "bus addr", g_addr[i], e_addr[i]);
      if (e_cmd[i] != 1) chk(g_data[i] == e_data[i], etag, "bus data", g_data[i], e_data[i]);
    end
    if (op == 0) chk(got_rd == exp_rd, etag, "read data", int'(got_rd), int'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) begin
      mem[a] = DW'(a * 97 + 13); ref_mem[a] = DW'(a * 97 + 13);
    end
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = 0; m_st[i] = 0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!req_ready && !bus_req, "R1", "idle outputs in reset", int'({req_ready, bus_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready && !bus_req, "R1", "idle outputs after reset", int'({req_ready, bus_req}), 0);
    // R1: address 0 in empty cache must miss
    do_req(0, 0, '0, 0, 0, 1);
    chk(gcnt == 1 && g_cmd[0] == 1, "R1", "first access misses", gcnt, 1);
    // R11: shared high during waits, low at done -> exclusive -> silent write
    do_req(0, 5, '0, 0, 0, 2);
    do_req(1, 5, 16'h1234, 0, 0, 0);
    chk(gcnt == 0, "R11", "waiting-cycle shared ignored", gcnt, 0);
    // directed: shared fill, write-through staying shared then turning exclusive
    do_req(0, 6, '0, 1, 0, 1);
    do_req(1, 6, 16'h0A0A, 0, 1, 2);
    do_req(1, 6, 16'h0B0B, 0, 0, 1);
    do_req(1, 6, 16'h0C0C, 0, 0, 0);
    do_req(2, 6, '0, 0, 0, 0);
    do_req(2, 6, '0, 0, 0, 0);
    // write misses both ways, dirty victim replacement, back-to-back zero latency
    do_req(1, 7, 16'h7777, 0, 0, 0);
    do_req(1, 11, 16'hBBBB, 1, 1, 0);
    do_req(0, 7, '0, 0, 0, 0);
    do_req(1, 15, 16'hF0F0, 0, 0, 1);
    do_req(0, 3, '0, 0, 0, 0);
    // near-exhaustive sweep over ops, tags, shared patterns and latencies
    for (int n = 0; n < 600; n++) begin
      int op, a;
      lfsr = step(lfsr); lfsr = step(lfsr); lfsr = step(lfsr);
      op = (lfsr[3:0] < 7) ? 0 : (lfsr[3:0] < 13) ? 1 : 2 + int'(lfsr[4]);
      a  = int'(lfsr[6:5]) * NL * 4 + int'(lfsr[8:7]) * NL + int'(lfsr[10:9]);
      a  = a % NA;
      if (lfsr[6]) a = (a % (3 * NL));
      do_req(op, a, lfsr ^ 16'h5A5A, lfsr[11], lfsr[12], int'(lfsr[14:13]) % 3);
    end
    // final clean pass: every dirty line written back with its last word
    for (int a = 0; a < NA; a++) do_req(2, a, '0, 0, 0, 0);
    for (int a = 0; a < NA; a++)
      chk(mem[a] == ref_mem[a], "R9", "memory image", int'(mem[a]), int'(ref_mem[a]));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule